// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the sequence of column addresses for a single burst access to one open row of a synchronous graphics DRAM. It serves both a memory model and a memory controller. A start strobe captures a start column, a burst length code, an ordering (linear or interleaved) and a read/write flag. From the next cycle on, the block presents one column address per clock, together with a valid flag and a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block whose size is the burst length. A full-page burst walks the whole 256-column row in ascending order, wraps around, and runs until a stop strobe ends it. When the single-write mode is set, every write burst is one beat long, while reads keep the programmed length. A start strobe that arrives during a burst drops the old burst and begins the new one at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `validOut` and `lastOut` are 0 and `colAddr` is 0.
- R2: A start sampled on a rising edge makes `validOut` 1 after that edge, with `colAddr` equal to `startCol` (beat 0). Each later edge presents the next beat.
- R3: Length code 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `validOut` stays high for exactly that many cycles and then falls.
- R4: With `burstOrder`=0 (linear), beat i of a fixed burst of length L is `(startCol & ~(L-1)) | ((startCol + i) & (L-1))`.
- R5: With `burstOrder`=1 (interleaved), beat i of a fixed burst of length L is `(startCol & ~(L-1)) | ((startCol ^ i) & (L-1))`.
- R6: Any length code of 4 or more selects full page. Beat i is `(startCol + i) mod 256` whatever `burstOrder` is, the burst never ends by itself, and `lastOut` is never 1 during it.
- R7: `lastOut` is 1 exactly on the final beat of a fixed-length burst.
- R8: A stop sampled while a burst is active and no start is present makes `validOut` and `lastOut` 0 after that edge. A stop while idle has no effect.
- R9: With `singleWriteMode`=1, a write (`isRead`=0) is one beat long whatever the length code is. A read keeps its programmed length.
- R10: A start sampled during an active burst abandons it. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe for a new burst |
| stopIn | input | 1 | Burst stop strobe |
| startCol | input | 8 | First column of the burst |
| lenCode | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 4 and up: full page) |
| burstOrder | input | 1 | 0 linear, 1 interleaved |
| isRead | input | 1 | 1 read, 0 write |
| singleWriteMode | input | 1 | Forces write bursts to one beat |
| colAddr | output | 8 | Current column address |
| validOut | output | 1 | Beat on `colAddr` is valid |
| lastOut | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions take for granted that the inputs are free of X once reset is released. They also take for granted that start and stop are sampled only on rising edges, with start winning when both are high. The burst parameters only matter in the cycle in which start is high. The stimulus changes inputs only on falling edges and holds each strobe for exactly one cycle. Its fixed-length bursts run to completion or are ended by a deliberate stop or restart, and full-page bursts are always ended by a stop.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrderE;

  // strobes from control to address datapath
  typedef struct packed {
    logic load;        // capture a new start column
    logic advance;     // step to the next beat
    logic interleave;  // ordering to use for the captured burst
  } seqStrobeT;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int LEN_CODE_W = 3,
  parameter int MAX_LOG2   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startIn,
  input  logic                  stopIn,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  burstOrder,
  input  logic                  isRead,
  input  logic                  singleWriteMode,
  output seqStrobeT             strobe,
  output logic [COL_W-1:0]      newMask,
  output logic                  validOut,
  output logic                  lastOut
);

  localparam logic [LEN_CODE_W-1:0] FULL_CODE = LEN_CODE_W'(MAX_LOG2 + 1);
  localparam logic [COL_W-1:0]      ONE_COL   = COL_W'(1);

  logic             active;
  logic             fullPageReg;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] maskReg;
  logic             lastReg;
  logic             newFull;
  logic             forceSingle;
  logic             moreBeats;
  logic [COL_W-1:0] beatNext;

  // decode the burst parameters presented with the start strobe
  always_comb begin
    forceSingle = singleWriteMode && !isRead;
    newFull     = 1'b0;
    newMask     = '0;
    if (!forceSingle) begin
      if (lenCode >= FULL_CODE) begin
        newFull = 1'b1;
        newMask = '1;
      end else begin
        newMask = (ONE_COL << lenCode) - ONE_COL;
      end
    end
  end

  assign beatNext  = beatCnt + ONE_COL;
  assign moreBeats = fullPageReg || (beatCnt != maskReg);

  always_comb begin
    strobe.load       = startIn;
    strobe.advance    = active && !startIn && !stopIn && moreBeats;
    strobe.interleave = (burstOrder == ORDER_INTERLEAVE) && !newFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      fullPageReg <= 1'b0;
      beatCnt     <= '0;
      maskReg     <= '0;
      lastReg     <= 1'b0;
    end else if (startIn) begin
      active      <= 1'b1;
      fullPageReg <= newFull;
      beatCnt     <= '0;
      maskReg     <= newMask;
      lastReg     <= !newFull && (newMask == '0);
    end else if (active) begin
      if (stopIn || !moreBeats) begin
        active  <= 1'b0;
        lastReg <= 1'b0;
      end else begin
        beatCnt <= beatNext;
        lastReg <= !fullPageReg && (beatNext == maskReg);
      end
    end
  end

  assign validOut = active;
  assign lastOut  = lastReg;

  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> validOut);

  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lastOut && !startIn) |=> !validOut);

  assert_full_no_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    fullPageReg |-> !lastOut);

  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> validOut);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn && !startIn) |=> (!validOut && !lastOut));

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && singleWriteMode && !isRead) |=> lastOut);

endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] newMask,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] ONE_COL = COL_W'(1);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] offset;
  logic [COL_W-1:0] maskReg;
  logic             interleaveReg;
  logic [COL_W-1:0] lowBits;
  logic [COL_W-1:0] nextAddr;

  // low bits move inside the aligned block, high bits stay with the start
  always_comb begin
    lowBits  = interleaveReg ? (baseCol ^ offset) : (baseCol + offset);
    nextAddr = (baseCol & ~maskReg) | (lowBits & maskReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol       <= '0;
      offset        <= '0;
      maskReg       <= '0;
      interleaveReg <= 1'b0;
      colAddr       <= '0;
    end else if (strobe.load) begin
      baseCol       <= startCol;
      offset        <= ONE_COL;
      maskReg       <= newMask;
      interleaveReg <= strobe.interleave;
      colAddr       <= startCol;
    end else if (strobe.advance) begin
      offset  <= offset + ONE_COL;
      colAddr <= nextAddr;
    end
  end

  assert_load_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (colAddr == $past(startCol)));

  assert_block_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ((colAddr & ~maskReg) == $past(colAddr & ~maskReg)));

  assert_page_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !interleaveReg && (maskReg == '1))
      |=> (colAddr == $past(colAddr) + ONE_COL));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int LEN_CODE_W = 3,
  parameter int MAX_LOG2   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startIn,
  input  logic                  stopIn,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] lenCode,
  input  logic                  burstOrder,
  input  logic                  isRead,
  input  logic                  singleWriteMode,
  output logic [COL_W-1:0]      colAddr,
  output logic                  validOut,
  output logic                  lastOut
);

  seqStrobeT        strobe;
  logic [COL_W-1:0] newMask;

  burst_seq_ctrl #(
    .COL_W(COL_W), .LEN_CODE_W(LEN_CODE_W), .MAX_LOG2(MAX_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stopIn(stopIn),
    .lenCode(lenCode), .burstOrder(burstOrder), .isRead(isRead),
    .singleWriteMode(singleWriteMode), .strobe(strobe), .newMask(newMask),
    .validOut(validOut), .lastOut(lastOut)
  );

  burst_seq_addr #(.COL_W(COL_W)) u_addr (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .newMask(newMask), .colAddr(colAddr)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!validOut && !lastOut));

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       stopIn = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       burstOrder = 1'b0;
  logic       isRead = 1'b1;
  logic       singleWriteMode = 1'b0;
  logic [7:0] colAddr;
  logic       validOut;
  logic       lastOut;

  int checks = 0;
  int errors = 0;

  logic [7:0] expA[$];
  bit         expL[$];
  string      expT[$];

  always #5 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stopIn(stopIn),
    .startCol(startCol), .lenCode(lenCode), .burstOrder(burstOrder),
    .isRead(isRead), .singleWriteMode(singleWriteMode),
    .colAddr(colAddr), .validOut(validOut), .lastOut(lastOut)
  );

  // reference ordering, computed with plain arithmetic
  function automatic logic [7:0] refAddr(int s, int code, bit il, int i);
    int len, base, pos;
    if (code >= 4) return 8'((s + i) % 256);
    len  = 1 << code;
    base = s - (s % len);
    pos  = il ? ((s % len) ^ i) : ((s % len + i) % len);
    return 8'(base + pos);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic driveStart(int s, int code, bit il, bit rd, bit sw);
    startIn = 1'b1; startCol = 8'(s); lenCode = 3'(code);
    burstOrder = il; isRead = rd; singleWriteMode = sw;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // burst that runs to its natural end
  task automatic runFixed(int s, int code, bit il, bit rd, bit sw, string tag);
    int len = (sw && !rd) ? 1 : (1 << code);
    for (int i = 0; i < len; i++) begin
      expA.push_back(refAddr(s, code, il, i));
      expL.push_back(i == len - 1);
      expT.push_back(tag);
    end
    driveStart(s, code, il, rd, sw);
    repeat (len) @(negedge clk);
    check(validOut == 1'b0 && expA.size() == 0, "R3 burst end", validOut, 0);
  endtask

  // burst ended by a stop after n beats
  task automatic runStopped(int s, int code, bit il, int n, string tag);
    for (int i = 0; i < n; i++) begin
      expA.push_back(refAddr(s, code, il, i));
      expL.push_back(code < 4 && i == (1 << code) - 1);
      expT.push_back(tag);
    end
    driveStart(s, code, il, 1'b1, 1'b0);
    repeat (n - 1) @(negedge clk);
    stopIn = 1'b1;
    @(negedge clk);
    stopIn = 1'b0;
    check(validOut == 1'b0 && lastOut == 1'b0, "R8 stop", validOut, 0);
  endtask

  // monitor: pop and compare one expected beat per valid cycle
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (expA.size() == 0) begin
        check(1'b0, "R3 extra beat", colAddr, -1);
      end else begin
        logic [7:0] a;
        bit l;
        string t;
        a = expA.pop_front(); l = expL.pop_front(); t = expT.pop_front();
        check(colAddr == a && lastOut == l, t, {colAddr, 7'b0, lastOut}, {a, 7'b0, l});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(validOut == 0 && lastOut == 0 && colAddr == 0, "R1 reset", validOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: stop while idle is ignored
    stopIn = 1'b1;
    @(negedge clk);
    stopIn = 1'b0;
    check(validOut == 0 && lastOut == 0, "R8 idle stop", validOut, 0);

    // every fixed length, ordering and start column: R2 R3 R4 R5 R7
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 256; s++)
          runFixed(s, code, il[0], 1'b1, 1'b0, il ? "R2/R5/R7" : "R2/R4/R7");

    // full page with both ordering settings, every start: R6
    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 256; s++)
        runStopped(s, 4 + (s % 4), il[0], 3, "R6 page");
    runStopped(250, 4, 1'b0, 270, "R6 page wrap");
    runStopped(0, 7, 1'b1, 260, "R6 page interleave ignored");

    // stop inside a fixed burst: R8
    runStopped(13, 3, 1'b0, 3, "R8 fixed stop");
    runStopped(6, 3, 1'b1, 1, "R8 stop after first");

    // single-write mode: R9
    runFixed(21, 3, 1'b0, 1'b0, 1'b1, "R9 write single");
    runFixed(22, 2, 1'b1, 1'b1, 1'b1, "R9 read keeps length");
    runFixed(23, 3, 1'b0, 1'b0, 1'b0, "R9 write normal");
    runFixed(24, 4, 1'b0, 1'b0, 1'b1, "R9 page write single");

    // restart during a burst: R10
    for (int i = 0; i < 3; i++) begin
      expA.push_back(refAddr(40, 3, 1'b0, i)); expL.push_back(1'b0);
      expT.push_back("R10 old burst");
    end
    driveStart(40, 3, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      expA.push_back(refAddr(99, 2, 1'b1, i)); expL.push_back(i == 3);
      expT.push_back("R10 new burst");
    end
    driveStart(99, 2, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check(validOut == 0 && expA.size() == 0, "R10 restart end", validOut, 0);

    // restart during a full-page burst, with stop asserted together
    for (int i = 0; i < 2; i++) begin
      expA.push_back(refAddr(255, 4, 1'b0, i)); expL.push_back(1'b0);
      expT.push_back("R10 page old");
    end
    driveStart(255, 4, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    expA.push_back(refAddr(7, 0, 1'b0, 0)); expL.push_back(1'b1);
    expT.push_back("R10 start beats stop");
    stopIn = 1'b1;
    driveStart(7, 0, 1'b0, 1'b1, 1'b0);
    stopIn = 1'b0;
    @(negedge clk);
    check(validOut == 0 && expA.size() == 0, "R10 single after restart", validOut, 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule